// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block produces the serial clock for one master on a two-wire bus where the SCL line is wired-AND. Every device can only pull the line low or let it float high. The block times a low phase and a high phase with a single local counter. It watches the shared line through a two-flop synchronizer and locks its own timing to what the line really does. If another device keeps the line low after this master has let go, the block waits and does not count. If another master pulls the line low while this master is still counting its high phase, the block drops into a fresh low phase. That low phase is timed from the moment the line fell.

Because of these two rules, every master on the bus ends up following one common clock. The line stays high only as long as the fastest master allows, and it stays low until the slowest master lets go. Each time the synchronized line is seen to rise, the block gives a one-cycle strobe that the data shifter uses. When the enable is dropped, the block lets go of the line and goes idle. The low and high durations are programmable counts of system-clock cycles. Both the synchronizer and the state register add delay. To cover that delay, the block starts its counter part-way up whenever it reacts to something it saw on the line, so that the phases stay timed from the true edges of the line.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is asserted, `scl_drive_low` is 0 (line released) and `rise_strobe` is 0.
- R2: With no other device on the line, each low phase that this master starts from a high line lasts exactly `low_cnt` cycles. The first low phase begins in the cycle after `en` is first sampled high. Legal values of `low_cnt` are 2 or more.
- R3: With no other device on the line, the line stays released for exactly max(`high_cnt`, 4) cycles before this master pulls it low again.
- R4: After releasing, the block keeps `scl_drive_low` at 0 for as long as another device holds the line low. High-phase timing starts only once the synchronized line reads high.
- R5: If the line falls while this master is in its high phase, the block pulls low 3 cycles after the fall. It then keeps driving so that, counted from the fall, the line is low for max(`low_cnt`, 4) cycles unless another device holds it longer.
- R6: `rise_strobe` is a single-cycle pulse. It is high in the cycle that follows the second clock edge after the line rises. It never lasts two cycles in a row.
- R7: In the cycle after `en` is sampled low, `scl_drive_low` is 0 and `rise_strobe` is 0, and they stay 0 while `en` stays low.
- R8: While enabled, with several masters on the line, every complete low period of the line lasts at least `low_cnt` cycles.
- R9: While enabled, with several masters on the line, every complete high period of the line lasts at most max(`high_cnt`, 4) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock generation enable |
| low_cnt | input | CW (8) | Low-phase length in system-clock cycles |
| high_cnt | input | CW (8) | High-phase length in system-clock cycles |
| scl_in | input | 1 | Raw sampled level of the shared SCL line |
| scl_drive_low | output | 1 | Open-drain control: 1 pulls SCL low, 0 releases it |
| rise_strobe | output | 1 | One-cycle pulse for each rising edge seen on the line |

## Verification
The block is first run as the only master, with a long setting and then with the minimum setting. These runs separate correct phase lengths from off-by-one or latency errors, and they exercise the floor of 4 on the released period. A stretch is then applied: the line is held low across the end of the block's own low phase. This separates a block that waits from one that starts counting its high phase too early. A second behavioural master is added twice. In one run it has a short high and a long low, and in the other a long high and a short low. These runs check the restart of the low phase on an early fall, and they check that the low periods on the line only grow and the high periods only shrink. Single-cycle glitches during the high phase test the restart path at its tightest timing, and dropping the enable in the middle of traffic tests the return to idle.

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          rise_strobe
);

  localparam int SYNC_LEN = 2;
  localparam logic [CW-1:0] SEEN_LAG = CW'(SYNC_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [SYNC_LEN:0] taps;
  logic          line_now, line_prev;
  logic [CW:0]   cnt_next;
  logic          low_done, high_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) taps <= '1;
    else        taps <= {taps[SYNC_LEN-1:0], scl_in};

  assign line_now  = taps[SYNC_LEN-1];
  assign line_prev = taps[SYNC_LEN];

  assign cnt_next  = {1'b0, cnt} + 1'b1;
  assign low_done  = cnt_next >= {1'b0, low_cnt};
  assign high_done = cnt_next >= {1'b0, high_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE;
      cnt   <= '0;
    end else if (!en) begin
      phase <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        S_IDLE: begin
          phase <= S_LOW;
          cnt   <= '0;
        end
        S_LOW: begin
          if (low_done) begin
            phase <= S_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt_next[CW-1:0];
          end
        end
        S_WAIT: begin
          if (line_now) begin
            phase <= S_HIGH;
            cnt   <= SEEN_LAG;
          end
        end
        default: begin
          if (!line_now) begin
            phase <= S_LOW;
            cnt   <= SEEN_LAG;
          end else if (high_done) begin
            phase <= S_LOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt_next[CW-1:0];
          end
        end
      endcase
    end
  end

  assign scl_drive_low = (phase == S_LOW);
  assign rise_strobe   = (phase != S_IDLE) && line_now && !line_prev;

endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_drive_low,
  input logic rise_strobe
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!scl_drive_low && !rise_strobe));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_strobe |=> !rise_strobe);

  // R6
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_strobe |-> ($past(scl_in, 2) && !$past(scl_in, 3)));

  // R7
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low);

  // R7
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rise_strobe);

endmodule

bind scl_clock_sync scl_clock_sync_chk chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .rise_strobe(rise_strobe)
);

// File: tb/scl_clock_sync_test.sv
module scl_clock_sync_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] lowc = 8'd6;
  logic [7:0] highc = 8'd8;
  logic hold = 1'b0;
  logic m2_pull = 1'b0;
  logic scl_drive_low, rise_strobe;
  wire  scl_in = !scl_drive_low && !hold && !m2_pull;

  always #2.5 clk = ~clk;

  scl_clock_sync #(.CW(8)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(lowc), .high_cnt(highc),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .rise_strobe(rise_strobe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // line level seen during the last cycle (sampled at the falling edge)
  bit bus_n = 1'b1;

  // behavioural second master
  bit m2_on = 0;
  int m2_lo = 12, m2_hi = 3, m2_ph = 1, m2_t = 0;
  always @(posedge clk) begin
    if (!m2_on) begin
      m2_pull <= 1'b0;
      m2_ph = 1;
      m2_t = 0;
    end else begin
      case (m2_ph)
        0: begin
          m2_t++;
          if (m2_t >= m2_lo) begin m2_ph = 1; m2_pull <= 1'b0; end
        end
        1: if (bus_n) begin m2_ph = 2; m2_t = 1; end
        default: begin
          if (!bus_n) begin m2_ph = 0; m2_t = 1; m2_pull <= 1'b1; end
          else begin
            m2_t++;
            if (m2_t >= m2_hi) begin m2_ph = 0; m2_t = 0; m2_pull <= 1'b1; end
          end
        end
      endcase
    end
  end

  // reference model: md 0 idle, 1 pulling, 2 waiting, 3 released-timed
  int md = 0, t = 0;
  bit h1 = 1, h2 = 1, h3 = 1;
  bit ext_low = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = 0; t = 0; h1 = 1; h2 = 1; h3 = 1; ext_low = 0;
    end else begin
      if (!en) md = 0;
      else begin
        case (md)
          0: begin md = 1; t = 1; ext_low = 0; end
          1: if (t >= lowc) md = 2; else t++;
          2: if (h2) begin md = 3; t = 4; end
          default: begin
            if (!h2) begin md = 1; t = 4; ext_low = 1; end
            else if (t >= highc) begin md = 1; t = 1; ext_low = 0; end
            else t++;
          end
        endcase
      end
      h3 = h2; h2 = h1; h1 = bus_n;
    end
  end

  // run-length measurement of the line: 0 off, 1 exact, 2 bounds
  int meas = 0;
  int run = 0;
  bit prev_b = 1, first = 1;

  always @(negedge clk) begin
    bus_n = scl_in;
    if (rst_n) begin
      bit exp_drive, exp_str;
      string tg;
      exp_drive = (md == 1);
      exp_str = (md != 0) && h2 && !h3;
      case (md)
        0: tg = "R7";
        1: tg = ext_low ? "R5" : "R2";
        2: tg = "R4";
        default: tg = "R3";
      endcase
      chk(scl_drive_low == exp_drive, tg, scl_drive_low, exp_drive);
      chk(rise_strobe == exp_str, "R6", rise_strobe, exp_str);
    end
    if (rst_n && en && meas != 0) begin
      if (bus_n == prev_b) run++;
      else begin
        if (!first) begin
          if (prev_b) begin
            int eh;
            eh = (highc < 4) ? 4 : int'(highc);
            if (meas == 1) chk(run == eh, "R3", run, eh);
            else chk(run <= eh, "R9", run, eh);
          end else begin
            if (meas == 1) chk(run == int'(lowc), "R2", run, lowc);
            else chk(run >= int'(lowc), "R8", run, lowc);
          end
        end
        first = 0; run = 1; prev_b = bus_n;
      end
    end else begin
      first = 1; run = 0; prev_b = bus_n;
    end
  end

  task automatic restart(input int lo, input int hi, input int mode);
    @(posedge clk); #1;
    en = 0; meas = 0;
    repeat (3) @(posedge clk);
    #1;
    lowc = 8'(lo); highc = 8'(hi); meas = mode; en = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1", scl_drive_low, 0);
    chk(rise_strobe == 1'b0, "R1", rise_strobe, 0);
    @(posedge clk); #1 rst_n = 1;

    // lone master, long setting
    restart(6, 8, 1);
    repeat (150) @(posedge clk);
    // lone master, minimum setting (released floor of 4)
    restart(2, 2, 1);
    repeat (60) @(posedge clk);

    // stretch across our release (R4)
    restart(5, 10, 0);
    do @(negedge clk); while (!scl_drive_low);
    @(posedge clk); #1 hold = 1;
    repeat (20) @(posedge clk);
    #1 hold = 0;
    repeat (60) @(posedge clk);

    // second master: short high, long low
    m2_lo = 12; m2_hi = 3; m2_on = 1;
    restart(5, 20, 2);
    repeat (400) @(posedge clk);
    // second master: long high, short low
    m2_on = 0;
    @(posedge clk); #1 m2_lo = 3; m2_hi = 30; m2_on = 1;
    restart(9, 6, 2);
    repeat (400) @(posedge clk);

    // disable in the middle of traffic (R7)
    @(posedge clk); #1 en = 0; meas = 0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R7", scl_drive_low, 0);
    chk(rise_strobe == 1'b0, "R7", rise_strobe, 0);
    repeat (10) @(posedge clk);
    #1 m2_on = 0;

    // single-cycle glitches while released (R5)
    restart(4, 12, 0);
    repeat (30) @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      repeat (17) @(posedge clk);
      #1 hold = 1;
      @(posedge clk); #1 hold = 0;
    end
    repeat (60) @(posedge clk);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule